// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Master and Partial Reset

This block is a single-clock FIFO with an 18-bit data path and a depth set by a power-of-two parameter. The flag convention is fixed at master reset by sampling a mode pin. In standard mode the two main flags report empty and full, and a read request moves the head word into a registered output. In fall-through mode the same two pins report input-ready and output-ready, and the head word moves into the output register without a request. Three further active-low flags report almost-empty, half-full and almost-full. The almost-empty and almost-full thresholds come from two offset registers. A small parallel load port writes those registers.

Both resets are active-low. Each is asserted asynchronously and released inside the block two clock edges after the pin returns high. Master reset clears all state, loads both offsets with 7 and latches the mode pin. Partial reset clears the pointers, the word count, the output register and the output-valid state. It keeps the latched mode and both offsets. Writes are accepted only after a master reset has been applied since power-up.

Top module: `dualmode_fifo`

## Requirements
- R1: While master reset is active, the block samples `mode_pin`: 0 selects standard mode and 1 selects fall-through mode. `mode_pin` must be held until two clock edges after `mrst_n` rises. After reset in standard mode, `rflag_n`=0 and `wflag_n`=1. After reset in fall-through mode, `rflag_n`=1 and `wflag_n`=0.
- R2: After either reset, `ae_n`=0, `af_n`=1, `hf_n`=1 and `rd_data`=0.
- R3: In standard mode, `rflag_n` is 0 exactly when no word is stored and `wflag_n` is 0 exactly when DEPTH words are stored. Both flags reflect a write or read from the clock edge that performs it.
- R4: In fall-through mode, a word reaches the output register on the second clock edge after it is written into an empty FIFO, with no read request. `rflag_n` falls at that same edge. `rd_en` consumes the word held in the output register. With no `rd_en`, the output word and `rflag_n`=0 hold.
- R5: In fall-through mode, `wflag_n` is 1 exactly when the storage array holds DEPTH words. This count excludes the word in the output register.
- R6: A write while the storage is full changes nothing. A read while nothing is available changes nothing: `rd_data` holds and no pointer moves.
- R7: `hf_n` is 0 exactly when the occupancy exceeds DEPTH/2. In fall-through mode, occupancy counts the valid word in the output register as well as the stored words.
- R8: `ae_n` is 0 exactly when occupancy ≤ the almost-empty offset. `af_n` is 0 exactly when (capacity − occupancy) ≤ the almost-full offset. Capacity is DEPTH in standard mode and DEPTH+1 in fall-through mode.
- R9: Master reset loads 7 into both offsets. A cycle with `ofs_ld`=1 writes `ofs_val` into the almost-empty offset when `ofs_sel`=0 and into the almost-full offset when `ofs_sel`=1. The new value takes effect from that clock edge.
- R10: Partial reset keeps the latched mode, whatever `mode_pin` shows at that time, and keeps both offsets.
- R11: Words leave in the order they were accepted, with their values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| prst_n | input | 1 | Partial reset, active low, asynchronous assertion |
| mode_pin | input | 1 | Flag mode, sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| ofs_ld | input | 1 | Offset register load strobe |
| ofs_sel | input | 1 | Offset select: 0 almost-empty, 1 almost-full |
| ofs_val | input | log2(DEPTH)+1 | Offset value to load |
| rflag_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| wflag_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| ae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
Every flag is a decode of registered counts. It therefore reflects a write, a read or an offset load right after the clock edge that performs it. In standard mode a read also updates `rd_data` at that edge. In fall-through mode a word written into an empty FIFO reaches `rd_data` one edge later, so two edges after the write. The bench drives inputs on the falling edge and steps a cycle model of occupancy, output-valid state and output word at each rising edge. It compares every output one nanosecond after that edge. After a reset pin is released, the bench waits four falling edges before it checks the reset state. This covers the two-stage release.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } flag_mode_e;

  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dmf_rst_sync.sv
module dmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dmf_offsets.sv
module dmf_offsets #(
  parameter int CW      = 5,
  parameter int DEF_OFS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          sel,
  input  logic [CW-1:0] val,
  output logic [CW-1:0] ae_ofs,
  output logic [CW-1:0] af_ofs
);
  logic [CW-1:0] ofs_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    logic [CW-1:0] d;
    always_comb d = (ld && (sel == 1'(g))) ? val : ofs_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_q[g] <= CW'(DEF_OFS);
      else        ofs_q[g] <= d;
    end
  end

  assign ae_ofs = ofs_q[dmf_pkg::OFS_EMPTY];
  assign af_ofs = ofs_q[dmf_pkg::OFS_FULL];
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     rptr_q, rptr_d;
  logic [CW-1:0]     cnt_q,  cnt_d;

  always_comb begin
    wptr_d = push ? wptr_q + AW'(1) : wptr_q;
    rptr_d = pop  ? rptr_q + AW'(1) : rptr_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          fwft,
  input  logic [CW-1:0] mem_cnt,
  input  logic          ovalid,
  input  logic [CW-1:0] ae_ofs,
  input  logic [CW-1:0] af_ofs,
  output logic          rflag_n,
  output logic          wflag_n,
  output logic          ae_n,
  output logic          hf_n,
  output logic          af_n
);
  localparam int OW   = CW + 1;
  localparam int HALF = DEPTH / 2;

  logic [OW-1:0] occ;
  logic [OW-1:0] cap;
  logic [OW-1:0] room;
  logic          stored_none;
  logic          stored_all;

  always_comb begin
    occ         = OW'(mem_cnt) + OW'(fwft & ovalid);
    cap         = OW'(DEPTH) + OW'(fwft);
    room        = cap - occ;
    stored_none = (mem_cnt == '0);
    stored_all  = (mem_cnt == CW'(DEPTH));
    if (fwft) begin
      rflag_n = ~ovalid;
      wflag_n = stored_all;
    end else begin
      rflag_n = ~stored_none;
      wflag_n = ~stored_all;
    end
    ae_n = ~(occ <= OW'(ae_ofs));
    hf_n = ~(occ > OW'(HALF));
    af_n = ~(room <= OW'(af_ofs));
  end
endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo #(
  parameter int DATA_W     = 18,
  parameter int DEPTH      = 16,
  parameter int OFS_RESET  = 7,
  parameter int RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   mrst_n,
  input  logic                   prst_n,
  input  logic                   mode_pin,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ofs_ld,
  input  logic                   ofs_sel,
  input  logic [$clog2(DEPTH):0] ofs_val,
  output logic                   rflag_n,
  output logic                   wflag_n,
  output logic                   ae_n,
  output logic                   hf_n,
  output logic                   af_n
);
  import dmf_pkg::*;

  localparam int CW = $clog2(DEPTH) + 1;

  logic rst_m_n;
  logic rst_p_n;
  logic rst_all_n;

  dmf_rst_sync #(.STAGES(RST_STAGES)) u_sync_m (
    .clk(clk), .arst_n(mrst_n), .rst_n(rst_m_n)
  );
  dmf_rst_sync #(.STAGES(RST_STAGES)) u_sync_p (
    .clk(clk), .arst_n(prst_n), .rst_n(rst_p_n)
  );
  assign rst_all_n = rst_m_n & rst_p_n;

  // configuration latched while master reset is held
  flag_mode_e mode_q, mode_d;
  logic       cfg_q,  cfg_d;
  logic       fwft;

  always_comb begin
    mode_d = rst_m_n ? mode_q : flag_mode_e'(mode_pin);
    cfg_d  = rst_m_n ? cfg_q  : 1'b1;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
    cfg_q  <= cfg_d;
  end

  assign fwft = (mode_q == MODE_FWFT);

  // storage
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     mem_cnt;
  logic              push;
  logic              pop;
  logic              ovalid_q, ovalid_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              have_word;

  always_comb begin
    have_word = (mem_cnt != '0);
    push      = wr_en & cfg_q & (mem_cnt != CW'(DEPTH));
    if (fwft) pop = have_word & (~ovalid_q | rd_en);
    else      pop = have_word & rd_en;
  end

  dmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_all_n),
    .push  (push),
    .pop   (pop),
    .wdata (wr_data),
    .head  (head),
    .count (mem_cnt)
  );

  // output register and fall-through valid bit
  always_comb begin
    out_d    = pop ? head : out_q;
    ovalid_d = fwft ? (pop | (ovalid_q & ~rd_en)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      out_q    <= '0;
      ovalid_q <= 1'b0;
    end else begin
      out_q    <= out_d;
      ovalid_q <= ovalid_d;
    end
  end

  assign rd_data = out_q;

  // thresholds
  logic [CW-1:0] ae_ofs;
  logic [CW-1:0] af_ofs;

  dmf_offsets #(.CW(CW), .DEF_OFS(OFS_RESET)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_m_n),
    .ld     (ofs_ld),
    .sel    (ofs_sel),
    .val    (ofs_val),
    .ae_ofs (ae_ofs),
    .af_ofs (af_ofs)
  );

  dmf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .fwft    (fwft),
    .mem_cnt (mem_cnt),
    .ovalid  (ovalid_q),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs),
    .rflag_n (rflag_n),
    .wflag_n (wflag_n),
    .ae_n    (ae_n),
    .hf_n    (hf_n),
    .af_n    (af_n)
  );
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rst_m_n,
  input logic                   fwft,
  input logic                   rd_en,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   rflag_n,
  input logic                   wflag_n,
  input logic                   hf_n,
  input logic [$clog2(DEPTH):0] mem_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= CW'(DEPTH));

  assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !wflag_n) |-> rflag_n);

  assert_empty_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !rflag_n && rd_en) |=> $stable(rd_data));

  assert_fwft_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !rflag_n && !rd_en) |=> (!rflag_n && $stable(rd_data)));

  assert_half_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !hf_n) |-> rflag_n);

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (!rst_m_n)
    rst_m_n |=> $stable(fwft));
endmodule

bind dualmode_fifo dmf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_all_n),
  .rst_m_n (rst_m_n),
  .fwft    (fwft),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .rflag_n (rflag_n),
  .wflag_n (wflag_n),
  .hf_n    (hf_n),
  .mem_cnt (mem_cnt)
);

// File: tb/test_dualmode_fifo.sv
module test_dualmode_fifo;
  localparam int W  = 18;
  localparam int D  = 8;
  localparam int CW = $clog2(D) + 1;

  logic          clk = 1'b0;
  logic          mrst_n = 1'b0;
  logic          prst_n = 1'b1;
  logic          mode_pin = 1'b0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en = 1'b0;
  logic [W-1:0]  rd_data;
  logic          ofs_ld = 1'b0;
  logic          ofs_sel = 1'b0;
  logic [CW-1:0] ofs_val = '0;
  logic          rflag_n, wflag_n, ae_n, hf_n, af_n;

  int checks = 0;
  int errors = 0;

  // cycle model
  logic [W-1:0] mq[$];
  logic         m_fwft = 1'b0;
  logic         m_ov = 1'b0;
  logic [W-1:0] m_out = '0;
  int           m_ae = 7;
  int           m_af = 7;
  int           wseq = 0;

  dualmode_fifo #(.DATA_W(W), .DEPTH(D)) i_dualmode_fifo (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_pin(mode_pin),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
    .rflag_n(rflag_n), .wflag_n(wflag_n), .ae_n(ae_n), .hf_n(hf_n), .af_n(af_n)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int s, occ, cap;
    s   = mq.size();
    occ = s + ((m_fwft && m_ov) ? 1 : 0);
    cap = D + (m_fwft ? 1 : 0);
    if (m_fwft) begin
      chk("R4", "rflag_n(or)", 32'(rflag_n), 32'(!m_ov));
      chk("R5", "wflag_n(ir)", 32'(wflag_n), 32'(s == D));
      chk("R4_R11", "rd_data", 32'(rd_data), 32'(m_out));
    end else begin
      chk("R3", "rflag_n(empty)", 32'(rflag_n), 32'(s != 0));
      chk("R3", "wflag_n(full)", 32'(wflag_n), 32'(s != D));
      chk("R11", "rd_data", 32'(rd_data), 32'(m_out));
    end
    chk("R7", "hf_n", 32'(hf_n), 32'(!(occ > D/2)));
    chk("R8", "ae_n", 32'(ae_n), 32'(!(occ <= m_ae)));
    chk("R8", "af_n", 32'(af_n), 32'(!((cap - occ) <= m_af)));
  endtask

  task automatic step(input logic w, input logic r);
    logic [W-1:0] wd;
    int s;
    logic load;
    @(negedge clk);
    wd = W'(wseq * 37 + 5);
    wseq++;
    wr_en = w; rd_en = r; wr_data = wd;
    @(posedge clk);
    s = mq.size();
    if (m_fwft) begin
      load = (s > 0) && (!m_ov || r);
      m_ov = load || (m_ov && !r);
      if (load) m_out = mq.pop_front();
    end else if (r && s > 0) begin
      m_out = mq.pop_front();
    end
    if (w && s < D) mq.push_back(wd);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    check_all();
  endtask

  task automatic check_reset(input string tag);
    if (m_fwft) begin
      chk("R1", "rflag_n after reset", 32'(rflag_n), 32'd1);
      chk("R1", "wflag_n after reset", 32'(wflag_n), 32'd0);
    end else begin
      chk("R1", "rflag_n after reset", 32'(rflag_n), 32'd0);
      chk("R1", "wflag_n after reset", 32'(wflag_n), 32'd1);
    end
    chk(tag, "ae_n after reset", 32'(ae_n), 32'd0);
    chk(tag, "af_n after reset", 32'(af_n), 32'd1);
    chk(tag, "hf_n after reset", 32'(hf_n), 32'd1);
    chk(tag, "rd_data after reset", 32'(rd_data), 32'd0);
  endtask

  task automatic master_reset(input logic m);
    @(negedge clk);
    mode_pin = m;
    mrst_n = 1'b0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge clk);
    mode_pin = ~m;
    mq.delete();
    m_fwft = m; m_ov = 1'b0; m_out = '0; m_ae = 7; m_af = 7;
    #1;
    check_reset("R2");
  endtask

  // mode pin shows the opposite value to prove it is not resampled (R10)
  task automatic partial_reset();
    @(negedge clk);
    mode_pin = ~m_fwft;
    prst_n = 1'b0;
    repeat (3) @(negedge clk);
    prst_n = 1'b1;
    repeat (4) @(negedge clk);
    mq.delete();
    m_ov = 1'b0; m_out = '0;
    #1;
    check_reset("R2_R10");
  endtask

  task automatic load_ofs(input logic sel, input int v);
    @(negedge clk);
    ofs_ld = 1'b1; ofs_sel = sel; ofs_val = CW'(v);
    @(posedge clk);
    if (sel) m_af = v; else m_ae = v;
    #1;
    ofs_ld = 1'b0;
    check_all();
  endtask

  task automatic sweep();
    for (int i = 0; i < D + 3; i++) step(1'b1, 1'b0);   // R6 overflow
    for (int i = 0; i < D + 3; i++) step(1'b0, 1'b1);   // R6 underflow
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 8; k++) step(p[k], p[(k + 3) % 8]);
    end
    for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      master_reset(1'(m));                         // R1 R2 R9
      sweep();
      load_ofs(1'b0, 2);                           // R9
      load_ofs(1'b1, 3);                           // R9
      sweep();                                     // R8 with new offsets
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      partial_reset();                             // R10
      sweep();                                     // offsets 2/3 and mode kept: R10
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      master_reset(1'(m));                         // R9 defaults back to 7
      for (int i = 0; i < D + 1; i++) step(1'b1, 1'b0);
      for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule